// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block multiplies two signed 8-bit operands on every rising clock edge. It either starts a new running total with that product or adds the product to the total it already holds. The total is a 19-bit signed register. That width is enough for the exact dot product of two eight-element signed byte vectors, so a filter tap loop or a matrix row-by-column product can stream one operand pair per cycle.

The load control starts a new sum. It does not zero the register first: it writes the current product straight into it. The first term of the next dot product therefore enters in the same cycle that the previous result is retired, and no cycle is lost. An active-low asynchronous reset puts the register at zero. A parameter selects the multiplier: either a native signed multiply or an explicit shift-and-add array.

Top module: `mac_unit`

## Requirements
- R1: While rst_ni is low, sum_o is zero, independent of the clock and the operands.
- R2: At a rising edge with clear_i = 1, sum_o becomes the signed product x_i*y_i, sign-extended to 19 bits, and the previous total is discarded.
- R3: At a rising edge with clear_i = 0, sum_o becomes its previous value plus x_i*y_i, taken modulo 2^19 as a two's-complement value.
- R4: sum_o changes only at a clock edge or on reset. Changing x_i, y_i or clear_i between edges leaves sum_o unchanged.
- R5: The extreme operands give exact products: -128*-128 = 16384, -128*127 = -16256 and 127*127 = 16129.
- R6: Eight terms are accumulated after a load (the load plus seven adds) with no overflow, even when every term is an extreme product. The result is exactly 131072 or -130048.
- R7: A run longer than the safe length wraps modulo 2^19. For example, twenty terms of 16384 read back as -196608.
- R8: Back-to-back loads each give just the new product, with no leftover from the term before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all updates on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the sum |
| x_i | input | 8 | First operand, two's-complement signed |
| y_i | input | 8 | Second operand, two's-complement signed |
| clear_i | input | 1 | 1: load the product; 0: add the product to the sum |
| sum_o | output | 19 | Registered signed running sum |

## Verification
The bound checker checks four things on every cycle. It checks the load and add update rules against the operands of the previous edge, including the 19-bit wrap. It checks that reset holds the sum at zero. It also counts the terms since the last load and keeps the sum inside the bounds of eight extreme products. The bench's scenarios show what the per-cycle properties cannot: that operand changes between edges have no effect on the output, the exact extreme products and the wrapped value of a long run, and an asynchronous reset in the middle of a run.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;

  typedef enum logic {
    MODE_ADD  = 1'b0,
    MODE_LOAD = 1'b1
  } acc_mode_e;

  // Sign-extend a product to the accumulator width.
  function automatic logic [63:0] sext64(input logic [63:0] v, input int unsigned w);
    logic [63:0] r;
    r = v;
    for (int unsigned k = 0; k < 64; k++) begin
      if (k >= w) r[k] = v[w-1];
    end
    return r;
  endfunction

endpackage

// File: rtl/mac_mult.sv
`timescale 1ns/1ps
module mac_mult #(
  parameter int unsigned OP_W      = 8,
  parameter bit          SHIFT_ADD = 1'b0,
  localparam int unsigned P_W      = 2 * OP_W
) (
  input  logic signed [OP_W-1:0] a_i,
  input  logic signed [OP_W-1:0] b_i,
  output logic signed [P_W-1:0]  p_o
);

  generate
    if (!SHIFT_ADD) begin : g_native
      assign p_o = P_W'(a_i) * P_W'(b_i);
    end else begin : g_array
      logic [P_W-1:0] a_ext;
      logic [P_W-1:0] pp [OP_W];
      logic [P_W-1:0] acc;

      assign a_ext = {{OP_W{a_i[OP_W-1]}}, a_i};

      for (genvar k = 0; k < OP_W; k++) begin : g_pp
        assign pp[k] = b_i[k] ? (a_ext << k) : '0;
      end

      // the sign bit of b carries negative weight
      always_comb begin
        acc = '0;
        for (int unsigned k = 0; k < OP_W - 1; k++) acc = acc + pp[k];
        acc = acc - pp[OP_W-1];
      end

      assign p_o = signed'(acc);
    end
  endgenerate

endmodule

// File: rtl/mac_acc_reg.sv
`timescale 1ns/1ps
module mac_acc_reg
  import mac_pkg::*;
#(
  parameter int unsigned P_W   = 16,
  parameter int unsigned ACC_W = 19
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  acc_mode_e               mode_i,
  input  logic signed [P_W-1:0]   prod_i,
  output logic signed [ACC_W-1:0] sum_o
);

  logic signed [ACC_W-1:0] prod_ext;
  logic signed [ACC_W-1:0] sum_d;
  logic signed [ACC_W-1:0] sum_q;

  assign prod_ext = {{(ACC_W-P_W){prod_i[P_W-1]}}, prod_i};

  always_comb begin
    unique case (mode_i)
      MODE_LOAD: sum_d = prod_ext;
      default:   sum_d = sum_q + prod_ext;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_d;
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/mac_unit.sv
`timescale 1ns/1ps
module mac_unit
  import mac_pkg::*;
#(
  parameter int unsigned OP_W           = 8,
  parameter int unsigned ACC_W          = 19,
  parameter bit          MULT_SHIFT_ADD = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [OP_W-1:0]  x_i,
  input  logic signed [OP_W-1:0]  y_i,
  input  logic                    clear_i,
  output logic signed [ACC_W-1:0] sum_o
);

  localparam int unsigned P_W = 2 * OP_W;

  logic signed [P_W-1:0] prod;
  acc_mode_e             mode;

  assign mode = clear_i ? MODE_LOAD : MODE_ADD;

  mac_mult #(
    .OP_W      (OP_W),
    .SHIFT_ADD (MULT_SHIFT_ADD)
  ) u_mult (
    .a_i (x_i),
    .b_i (y_i),
    .p_o (prod)
  );

  mac_acc_reg #(
    .P_W   (P_W),
    .ACC_W (ACC_W)
  ) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .prod_i (prod),
    .sum_o  (sum_o)
  );

endmodule

// File: rtl/mac_unit_chk.sv
`timescale 1ns/1ps
module mac_unit_chk #(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned ACC_W = 19
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic signed [OP_W-1:0]  x_i,
  input logic signed [OP_W-1:0]  y_i,
  input logic                    clear_i,
  input logic signed [ACC_W-1:0] sum_o
);

  localparam int DOT_TERMS = 8;
  localparam int MAX_PROD  = 2 ** (2 * OP_W - 2);
  localparam int MIN_PROD  = -(2 ** (OP_W - 1)) * (2 ** (OP_W - 1) - 1);

  logic signed [ACC_W-1:0] prod_ext;
  logic [4:0]              terms;

  assign prod_ext = ACC_W'(x_i) * ACC_W'(y_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             terms <= '0;
    else if (clear_i)        terms <= 5'd1;
    else if (terms != '0 && terms != 5'd31) terms <= terms + 5'd1;
  end

  always @(negedge clk_i) begin
    if (!rst_ni) AST_RESET_ZERO: assert (sum_o == '0); // R1
  end

  AST_LOAD_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> sum_o == $past(prod_ext)); // R2

  AST_ADD_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> sum_o == ACC_W'($past(sum_o) + $past(prod_ext))); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (terms != '0 && int'(terms) <= DOT_TERMS) |->
      (int'(sum_o) <= int'(terms) * MAX_PROD && int'(sum_o) >= int'(terms) * MIN_PROD)); // R6

endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .x_i     (x_i),
  .y_i     (y_i),
  .clear_i (clear_i),
  .sum_o   (sum_o)
);

// File: tb/sim_mac_unit.sv
`timescale 1ns/1ps
module sim_mac_unit;

  localparam int OP_W  = 8;
  localparam int ACC_W = 19;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic signed [OP_W-1:0]  x_i = '0;
  logic signed [OP_W-1:0]  y_i = '0;
  logic                    clear_i = 1'b0;
  logic signed [ACC_W-1:0] sum_o;

  int    n_vec  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  longint expv  = 0;

  always #10 clk_i = ~clk_i;

  mac_unit u0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .x_i     (x_i),
    .y_i     (y_i),
    .clear_i (clear_i),
    .sum_o   (sum_o)
  );

  function automatic longint wrap(input longint v);
    longint m;
    m = v & ((64'sd1 <<< ACC_W) - 1);
    if (m >= (64'sd1 <<< (ACC_W - 1))) m = m - (64'sd1 <<< ACC_W);
    return m;
  endfunction

  task automatic check(input string tag, input longint want);
    n_vec++;
    if ($isunknown(sum_o) || longint'(sum_o) != want) begin
      n_fail++;
      $display("FAIL %s: sum_o=%0d expected=%0d", tag, sum_o, want);
    end
  endtask

  // drive after a falling edge, model the update, compare at the next falling edge
  task automatic step(input int a, input int b, input bit c, input string tag);
    longint p;
    x_i = OP_W'(a); y_i = OP_W'(b); clear_i = c;
    p = longint'(a) * longint'(b);
    expv = c ? wrap(p) : wrap(expv + p);
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag, expv);
  endtask

  task automatic glitch(input string tag);
    x_i = 8'sd99; y_i = -8'sd77; clear_i = ~clear_i;
    #3;
    check(tag, expv);
    x_i = -8'sd5; y_i = 8'sd44;
    #3;
    check(tag, expv);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    x_i = 8'sd33; y_i = 8'sd17; clear_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 reset", 0);
    rst_ni = 1'b1;

    // R2 loads of assorted signs
    step(  3,   4, 1, "R2 load");
    step( -7,   9, 1, "R2 load neg");
    step(-11, -13, 1, "R2 load negneg");
    step(  0, 100, 1, "R2 load zero");

    // R3 accumulate
    step(  5,   6, 1, "R3 start");
    step( 10,  -2, 0, "R3 add");
    step(-20,   3, 0, "R3 add");
    step(  1,   1, 0, "R3 add");

    // R5 extremes
    step(-128, -128, 1, "R5 minmin");
    step(-128,  127, 1, "R5 minmax");
    step( 127,  127, 1, "R5 maxmax");
    if (expv != 16129) begin n_fail++; $display("FAIL R5 model: got=%0d expected=16129", expv); end

    // R6 eight extreme terms, both signs
    step(-128, -128, 1, "R6 max start");
    for (int k = 0; k < 7; k++) step(-128, -128, 0, "R6 max add");
    check("R6 max total", 131072);
    step(-128, 127, 1, "R6 min start");
    for (int k = 0; k < 7; k++) step(127, -128, 0, "R6 min add");
    check("R6 min total", -130048);

    // R7 wrap on a long run
    step(-128, -128, 1, "R7 start");
    for (int k = 0; k < 19; k++) step(-128, -128, 0, "R7 add");
    check("R7 wrapped", -196608);

    // R8 back-to-back loads
    step(50, 50, 0, "R8 prime");
    step(-3, 7, 1, "R8 load");
    step(4, 4, 1, "R8 load");
    step(-1, -1, 1, "R8 load");

    // R4 operand changes between edges
    step(9, 9, 0, "R4 setup");
    glitch("R4 hold");
    step(2, 2, 0, "R4 after");
    glitch("R4 hold");

    // R1 asynchronous reset mid-run
    step(100, 100, 1, "R1 pre");
    #4 rst_ni = 1'b0;
    #1 check("R1 async", 0);
    expv = 0;
    @(negedge clk_i);
    check("R1 held", 0);
    rst_ni = 1'b1;
    step(6, 7, 0, "R3 from reset");

    // mixed traffic
    for (int k = 0; k < 300; k++) begin
      int a, b;
      bit c;
      a = int'($urandom_range(255)) - 128;
      b = int'($urandom_range(255)) - 128;
      c = ($urandom_range(5) == 0);
      step(a, b, c, c ? "R2 mix" : "R3 mix");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule